// File: doc/BRIEF.md
# Synchronizable Free-Running Message Timer

This block keeps a 16-bit count for a CAN controller. The count moves up by one on every cycle in which the bit-clock tick input is high. After 0xFFFF it rolls over to 0x0000. Software can read the count at any time on `count_o`. It can load a new count through a write strobe and a data bus.

The count can also serve as a shared network time base. When synchronization is armed, a completed reception into the trigger mailbox clears the count to zero. The trigger mailbox is normally mailbox 0. When the receive FIFO is enabled, the trigger is instead the first free mailbox index that the FIFO configuration supplies.

The arming bit may only change while the controller is frozen. A configuration write made outside freeze leaves the bit unchanged. The arming bit is read back on `sync_en_o`. The bit engine, the acceptance filters and the message storage sit outside this block. Only the reception strobe and its mailbox index stand for them here.

Top module: `msg_timer_sync`

## Requirements
- R1: After reset, `count_o` is 0x0000 and `sync_en_o` is 0.
- R2: A cycle with `tick_i` high, and no write and no synchronization, raises `count_o` by one after the clock edge. A count of 0xFFFF becomes 0x0000.
- R3: A cycle with `cpu_wr_i` high and no synchronization loads `cpu_wdata_i` into the count after the clock edge. This holds even if `tick_i` is also high.
- R4: When synchronization is armed and `rx_fifo_en_i` is 0, a cycle with `rx_done_i` high and `rx_mb_i` equal to 0 clears the count. A reception into any other mailbox leaves the count unchanged.
- R5: When synchronization is armed and `rx_fifo_en_i` is 1, the trigger mailbox is `fifo_first_mb_i`. A reception into that index clears the count. A reception into mailbox 0 (when 0 is not the configured index) does not.
- R6: When `sync_en_o` is 0, receptions never change the count.
- R7: `cfg_wr_i` loads `cfg_sync_en_i` into the arming bit only when `freeze_i` is 1. Otherwise the write is ignored. A new setting takes effect from the next cycle.
- R8: When a synchronization clear and a software write fall in the same cycle, the count becomes 0x0000.
- R9: When a synchronization clear and a tick fall in the same cycle, the count becomes 0x0000, not 0x0001.
- R10: With no tick, no write and no synchronization, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Bit-clock tick; advances the count |
| cpu_wr_i | input | 1 | Software write strobe for the count |
| cpu_wdata_i | input | 16 | Value to load into the count |
| freeze_i | input | 1 | Controller is in freeze mode |
| cfg_wr_i | input | 1 | Write strobe for the arming bit |
| cfg_sync_en_i | input | 1 | New value of the arming bit |
| rx_fifo_en_i | input | 1 | Receive FIFO enabled |
| fifo_first_mb_i | input | 6 | First free mailbox index under the FIFO setting |
| rx_done_i | input | 1 | A reception completed this cycle |
| rx_mb_i | input | 6 | Mailbox that took the reception |
| count_o | output | 16 | Current count |
| sync_en_o | output | 1 | Arming bit readback |

## Verification
The bench builds the block with its default widths: a 16-bit count and 6-bit mailbox indices. With these widths the rollover from 0xFFFF can be reached in one step, by loading 0xFFFF through the write port and then applying one tick. The 6-bit index makes a non-zero FIFO trigger mailbox such as 5 available. That lets the bench show that mailbox 0 stops triggering once the FIFO is enabled, and that the configured index triggers instead.

// File: rtl/tmr_sync_pkg.sv
package tmr_sync_pkg;

    // Next-cycle action on the count, in falling priority:
    // clear > load > increment > hold.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/tmr_cfg_lock.sv
module tmr_cfg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze_i,
    input  logic cfg_wr_i,
    input  logic cfg_sync_en_i,
    output logic sync_en_o
);
    typedef struct packed {
        logic sync_en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Writes only land while frozen.
        if (cfg_wr_i && freeze_i) begin
            st_d.sync_en = cfg_sync_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_en_o = st_q.sync_en;
endmodule

// File: rtl/tmr_sync_match.sv
module tmr_sync_match #(
    parameter int MB_W = 6
) (
    input  logic            sync_en_i,
    input  logic            rx_done_i,
    input  logic [MB_W-1:0] rx_mb_i,
    input  logic            rx_fifo_en_i,
    input  logic [MB_W-1:0] fifo_first_mb_i,
    output logic            sync_hit_o
);
    localparam logic [MB_W-1:0] PLAIN_TRIG_MB = '0;

    logic [MB_W-1:0] trig_mb;

    always_comb begin
        trig_mb    = rx_fifo_en_i ? fifo_first_mb_i : PLAIN_TRIG_MB;
        sync_hit_o = sync_en_i && rx_done_i && (rx_mb_i == trig_mb);
    end
endmodule

// File: rtl/tmr_action_arb.sv
module tmr_action_arb
    import tmr_sync_pkg::*;
(
    input  logic     sync_hit_i,
    input  logic     cpu_wr_i,
    input  logic     tick_i,
    output cnt_act_e act_o
);
    always_comb begin
        if (sync_hit_i) begin
            act_o = ACT_CLEAR;
        end else if (cpu_wr_i) begin
            act_o = ACT_LOAD;
        end else if (tick_i) begin
            act_o = ACT_INC;
        end else begin
            act_o = ACT_HOLD;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_sync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_act_e         act_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act_i)
            ACT_CLEAR: st_d.cnt = '0;
            ACT_LOAD:  st_d.cnt = load_val_i;
            ACT_INC:   st_d.cnt = st_q.cnt + ONE; // wraps naturally
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/msg_timer_sync.sv
module msg_timer_sync
    import tmr_sync_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int MB_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cpu_wr_i,
    input  logic [CNT_W-1:0] cpu_wdata_i,
    input  logic             freeze_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_sync_en_i,
    input  logic             rx_fifo_en_i,
    input  logic [MB_W-1:0]  fifo_first_mb_i,
    input  logic             rx_done_i,
    input  logic [MB_W-1:0]  rx_mb_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sync_en_o
);
    logic     sync_en;
    logic     sync_hit;
    cnt_act_e act;

    tmr_cfg_lock u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .freeze_i     (freeze_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_sync_en_i(cfg_sync_en_i),
        .sync_en_o    (sync_en)
    );

    tmr_sync_match #(.MB_W(MB_W)) u_match (
        .sync_en_i      (sync_en),
        .rx_done_i      (rx_done_i),
        .rx_mb_i        (rx_mb_i),
        .rx_fifo_en_i   (rx_fifo_en_i),
        .fifo_first_mb_i(fifo_first_mb_i),
        .sync_hit_o     (sync_hit)
    );

    tmr_action_arb u_arb (
        .sync_hit_i(sync_hit),
        .cpu_wr_i  (cpu_wr_i),
        .tick_i    (tick_i),
        .act_o     (act)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .load_val_i(cpu_wdata_i),
        .count_o   (count_o)
    );

    assign sync_en_o = sync_en;
endmodule

// File: rtl/msg_timer_sync_chk.sv
module msg_timer_sync_chk #(
    parameter int CNT_W = 16,
    parameter int MB_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             cpu_wr_i,
    input logic [CNT_W-1:0] cpu_wdata_i,
    input logic             freeze_i,
    input logic             cfg_wr_i,
    input logic             cfg_sync_en_i,
    input logic             rx_fifo_en_i,
    input logic [MB_W-1:0]  fifo_first_mb_i,
    input logic             rx_done_i,
    input logic [MB_W-1:0]  rx_mb_i,
    input logic [CNT_W-1:0] count_o,
    input logic             sync_en_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic trig_seen;
    assign trig_seen = sync_en_o && rx_done_i &&
                       (rx_mb_i == (rx_fifo_en_i ? fifo_first_mb_i : '0));

    assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cpu_wr_i && !trig_seen && count_o != CNT_MAX)
        |=> count_o == $past(count_o) + CNT_W'(1));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cpu_wr_i && !trig_seen && count_o == CNT_MAX)
        |=> count_o == '0);

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && !trig_seen) |=> count_o == $past(cpu_wdata_i));

    // R4, R5, R8, R9: a trigger always clears, whatever else happens.
    assert_sync_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_seen |=> count_o == '0);

    assert_no_sync_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en_o && !tick_i && !cpu_wr_i) |=> $stable(count_o));

    assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_i |=> $stable(sync_en_o));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cpu_wr_i && !trig_seen) |=> $stable(count_o));
endmodule

bind msg_timer_sync msg_timer_sync_chk #(.CNT_W(CNT_W), .MB_W(MB_W)) u_chk (.*);

// File: tb/msg_timer_sync_bench.sv
module msg_timer_sync_bench;
    localparam int CNT_W = 16;
    localparam int MB_W  = 6;
    localparam int WDOG  = 20000;

    typedef struct packed {
        logic             tick;
        logic             wr;
        logic [CNT_W-1:0] wdata;
        logic             rx;
        logic [MB_W-1:0]  mb;
        logic             fifo;
        logic [MB_W-1:0]  first;
        logic [CNT_W-1:0] exp;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 16'h1234, 1'b0, 6'd0, 1'b0, 6'd0, 16'h1234, 4'd3},  // R3 load
        '{1'b1, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0, 16'h1235, 4'd2},  // R2 step
        '{1'b1, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0, 16'h1236, 4'd2},  // R2 step
        '{1'b0, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0, 16'h1236, 4'd10}, // R10 hold
        '{1'b0, 1'b0, 16'h0000, 1'b1, 6'd3, 1'b0, 6'd0, 16'h1236, 4'd4},  // R4 other mailbox
        '{1'b0, 1'b0, 16'h0000, 1'b1, 6'd0, 1'b0, 6'd0, 16'h0000, 4'd4},  // R4 mailbox 0 clears
        '{1'b0, 1'b1, 16'hFFFF, 1'b0, 6'd0, 1'b0, 6'd0, 16'hFFFF, 4'd3},  // R3 load max
        '{1'b1, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0, 16'h0000, 4'd2},  // R2 wrap
        '{1'b1, 1'b0, 16'h0000, 1'b0, 6'd0, 1'b0, 6'd0, 16'h0001, 4'd2},  // R2 after wrap
        '{1'b1, 1'b0, 16'h0000, 1'b1, 6'd0, 1'b1, 6'd5, 16'h0002, 4'd5},  // R5 mb0 ignored
        '{1'b0, 1'b0, 16'h0000, 1'b1, 6'd5, 1'b1, 6'd5, 16'h0000, 4'd5},  // R5 mb5 clears
        '{1'b1, 1'b1, 16'h00AA, 1'b0, 6'd0, 1'b0, 6'd0, 16'h00AA, 4'd3},  // R3 write beats tick
        '{1'b0, 1'b1, 16'h5555, 1'b1, 6'd0, 1'b0, 6'd0, 16'h0000, 4'd8},  // R8 sync beats write
        '{1'b0, 1'b1, 16'h0777, 1'b0, 6'd0, 1'b0, 6'd0, 16'h0777, 4'd3},  // R3 load
        '{1'b1, 1'b0, 16'h0000, 1'b1, 6'd0, 1'b0, 6'd0, 16'h0000, 4'd9}   // R9 sync with tick
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             cpu_wr_i = 1'b0;
    logic [CNT_W-1:0] cpu_wdata_i = '0;
    logic             freeze_i = 1'b0;
    logic             cfg_wr_i = 1'b0;
    logic             cfg_sync_en_i = 1'b0;
    logic             rx_fifo_en_i = 1'b0;
    logic [MB_W-1:0]  fifo_first_mb_i = '0;
    logic             rx_done_i = 1'b0;
    logic [MB_W-1:0]  rx_mb_i = '0;
    logic [CNT_W-1:0] count_o;
    logic             sync_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    msg_timer_sync #(.CNT_W(CNT_W), .MB_W(MB_W)) u_msg_timer_sync (.*);

    task automatic chk(input string tag, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tick_i = 0; cpu_wr_i = 0; cpu_wdata_i = '0; cfg_wr_i = 0;
        rx_done_i = 0; rx_mb_i = '0; rx_fifo_en_i = 0; fifo_first_mb_i = '0;
    endtask

    task automatic cfg_write(input logic frz, input logic val);
        @(negedge clk);
        freeze_i = frz; cfg_wr_i = 1; cfg_sync_en_i = val;
        @(negedge clk);
        cfg_wr_i = 0; freeze_i = 0;
    endtask

    task automatic step(input logic tk, input logic wr, input logic [CNT_W-1:0] wd,
                        input logic rx, input logic [MB_W-1:0] mb, input logic fifo,
                        input logic [MB_W-1:0] first);
        @(negedge clk);
        tick_i = tk; cpu_wr_i = wr; cpu_wdata_i = wd; rx_done_i = rx;
        rx_mb_i = mb; rx_fifo_en_i = fifo; fifo_first_mb_i = first;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count reset", count_o, '0);
        chk("R1 sync_en reset", CNT_W'(sync_en_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after release", count_o, '0);

        // R7: arm while frozen
        cfg_write(1'b1, 1'b1);
        chk("R7 armed in freeze", CNT_W'(sync_en_o), CNT_W'(1));

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].tick, VEC[i].wr, VEC[i].wdata, VEC[i].rx,
                 VEC[i].mb, VEC[i].fifo, VEC[i].first);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), count_o, VEC[i].exp);
        end

        // R7: disarm attempt outside freeze is ignored
        cfg_write(1'b0, 1'b0);
        chk("R7 write outside freeze ignored", CNT_W'(sync_en_o), CNT_W'(1));
        step(0, 1, 16'h0100, 0, 0, 0, 0);
        step(0, 0, 16'h0000, 1, 0, 0, 0);
        chk("R7 still clears after ignored write", count_o, '0);

        // R6: disarm in freeze, receptions then have no effect
        cfg_write(1'b1, 1'b0);
        chk("R6 disarmed", CNT_W'(sync_en_o), '0);
        step(0, 1, 16'h0200, 0, 0, 0, 0);
        step(0, 0, 16'h0000, 1, 0, 0, 0);
        chk("R6 mb0 no effect when off", count_o, 16'h0200);
        step(1, 0, 16'h0000, 1, 5, 1, 5);
        chk("R6 fifo trigger no effect when off", count_o, 16'h0201);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule